// File: doc/BRIEF.md
# Monitor channel byte receiver

This block sits on the receive side of the monitor channel of a frame-based serial link. On every frame the sender presents one data byte together with an E line that says whether the byte is meaningful. The receiver answers on an A line. A byte is accepted only after the same value has been seen in two consecutive E-active frames. Accepted bytes, end-of-message events and protocol problems are reported to software through one descriptor word that holds four flags and the data byte.

Software frees the descriptor with a read-done pulse. While the descriptor is occupied, the receiver holds back its acknowledge, which keeps the sender waiting. Two command pulses act on the receiver. The abort command drives an abort code on the A line. The init command returns the whole receiver to its reset state. Bit serialisation and the transmit side of the channel belong to other blocks.

Top module: `mon_rx_top`

## Requirements
- R1: The descriptor word has Empty at bit 0 (1 = free for a new entry), Last at bit 1, Error at bit 2 and Mismatch at bit 3. Bits 7:4 read zero and bits 15:8 hold the data byte. After reset the word reads 16'h0001.
- R2: A byte is written only when two consecutive frames with E active carry identical bytes and Empty is set. The write clears Empty, Last and Mismatch, loads the data field, and is visible in the clock cycle after the second frame strobe.
- R3: Two consecutive E-active frames with different bytes set Mismatch and write no data. Mismatch clears as soon as two consecutive bytes agree.
- R4: A read-done pulse sets Empty. While Empty is clear, a matched byte is held pending and is not acknowledged. It is written, with an acknowledge, on the first frame that repeats it after Empty has been set again.
- R5: If a byte is pending and a frame brings a different byte, Error is set and the pending byte is discarded. A read-done pulse clears Error.
- R6: The A line is a 2-bit code: 00 idle, 01 acknowledge, 10 abort. It is updated at each frame strobe and holds until the next one. A frame that writes a byte produces 01.
- R7: An abort command makes the next frame strobe drive 10 for ABORT_FRAMES frames (default 1), after which the code returns to its normal value. Abort overrides an acknowledge in the same frame.
- R8: After at least one byte has been accepted, IDLE_FRAMES (default 2) consecutive E-inactive frames, with no pending byte and Empty set, set Last, clear Empty and leave the data field unchanged. This happens once per message.
- R9: An init command returns the word to 16'h0001 and the A code to 00. It discards pending and partial bytes and any outstanding abort. Init wins over an abort issued in the same cycle.
- R10: After a byte has been written, a further copy of it alone does not write again. Two fresh identical copies are needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe_i | input | 1 | One-cycle pulse marking a new frame's monitor slot |
| e_active_i | input | 1 | Sender E line, 1 = byte valid in this frame |
| mon_byte_i | input | DATA_W | Monitor byte of this frame |
| rd_done_i | input | 1 | Software has consumed the descriptor (sets Empty) |
| abort_cmd_i | input | 1 | Abort request command pulse |
| init_cmd_i | input | 1 | Re-initialise command pulse |
| desc_word_o | output | DATA_W+8 | Descriptor: flags in bits 3:0, data in the top byte |
| a_code_o | output | 2 | A line code: 00 idle, 01 ack, 10 abort |

## Verification
The bench keeps DATA_W at 8 and IDLE_FRAMES at 2. It raises ABORT_FRAMES to 2, so the abort hold runs on its counter rather than on the single-frame shortcut, and the return to idle after exactly two frames can be seen. With IDLE_FRAMES at 2, the first idle frame after a message must leave the word untouched and the second must raise Last. That checks both sides of the end-of-message threshold in a short run.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
   typedef enum logic [1:0] {
      A_IDLE  = 2'b00,
      A_ACK   = 2'b01,
      A_ABORT = 2'b10
   } aline_e;

   localparam int BIT_EMPTY = 0;
   localparam int BIT_LAST  = 1;
   localparam int BIT_ERR   = 2;
   localparam int BIT_MIS   = 3;
   localparam int FLAG_W    = 8;
endpackage

// File: rtl/mon_rx_filter.sv
module mon_rx_filter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              strobe_i,
   input  logic              e_act_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              empty_i,
   output logic              wr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              set_err_o,
   output logic              set_mis_o,
   output logic              clr_mis_o,
   output logic              pend_o
);
   logic [DATA_W-1:0] prev_q, prev_d, pbyte_q, pbyte_d;
   logic              have_q, have_d, pend_q, pend_d;

   always_comb begin
      wr_o      = 1'b0;
      set_err_o = 1'b0;
      set_mis_o = 1'b0;
      clr_mis_o = 1'b0;
      prev_d    = prev_q;
      have_d    = have_q;
      pend_d    = pend_q;
      pbyte_d   = pbyte_q;
      if (strobe_i) begin
         if (!e_act_i) begin
            have_d = 1'b0;
         end else if (pend_q) begin
            if (byte_i == pbyte_q) begin
               if (empty_i) begin
                  wr_o   = 1'b1;
                  pend_d = 1'b0;
               end
            end else begin
               set_err_o = 1'b1;
               pend_d    = 1'b0;
               prev_d    = byte_i;
               have_d    = 1'b1;
            end
         end else if (have_q) begin
            if (byte_i == prev_q) begin
               clr_mis_o = 1'b1;
               have_d    = 1'b0;
               if (empty_i) begin
                  wr_o = 1'b1;
               end else begin
                  pend_d  = 1'b1;
                  pbyte_d = byte_i;
               end
            end else begin
               set_mis_o = 1'b1;
               prev_d    = byte_i;
            end
         end else begin
            prev_d = byte_i;
            have_d = 1'b1;
         end
      end
   end

   assign wr_data_o = byte_i;
   assign pend_o    = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         pbyte_q <= '0;
         have_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else if (init_i) begin
         prev_q  <= '0;
         pbyte_q <= '0;
         have_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         prev_q  <= prev_d;
         pbyte_q <= pbyte_d;
         have_q  <= have_d;
         pend_q  <= pend_d;
      end
   end

   // R10: a write consumes the matched pair
   p_fresh_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o && !init_i |=> !have_q && !pend_q);
endmodule

// File: rtl/mon_rx_eom.sv
module mon_rx_eom #(
   parameter int IDLE_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_i,
   input  logic strobe_i,
   input  logic e_act_i,
   input  logic pend_i,
   input  logic empty_i,
   input  logic wr_i,
   output logic eom_o
);
   logic open_q;
   logic idle_reached;

   generate
      if (IDLE_FRAMES == 1) begin : g_single
         assign idle_reached = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(IDLE_FRAMES + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (init_i) begin
               cnt_q <= '0;
            end else if (strobe_i) begin
               if (e_act_i) cnt_q <= '0;
               else if (cnt_q != CW'(IDLE_FRAMES)) cnt_q <= cnt_q + 1'b1;
            end
         end
         assign idle_reached = (cnt_q >= CW'(IDLE_FRAMES - 1));
      end
   endgenerate

   assign eom_o = strobe_i && !e_act_i && idle_reached && open_q && !pend_i && empty_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      open_q <= 1'b0;
      else if (init_i) open_q <= 1'b0;
      else if (wr_i)   open_q <= 1'b1;
      else if (eom_o)  open_q <= 1'b0;
   end

   // R8: one end-of-message per message
   p_eom_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eom_o && !init_i |=> !eom_o);
endmodule

// File: rtl/mon_rx_desc.sv
module mon_rx_desc
   import mon_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int WORD_W = DATA_W + FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              set_err_i,
   input  logic              set_mis_i,
   input  logic              clr_mis_i,
   input  logic              eom_i,
   input  logic              rd_done_i,
   output logic              empty_o,
   output logic [WORD_W-1:0] word_o
);
   logic              empty_q, last_q, err_q, mis_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         last_q  <= 1'b0;
         err_q   <= 1'b0;
         mis_q   <= 1'b0;
         data_q  <= '0;
      end else if (init_i) begin
         empty_q <= 1'b1;
         last_q  <= 1'b0;
         err_q   <= 1'b0;
         mis_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         if (wr_i) begin
            data_q  <= wr_data_i;
            empty_q <= 1'b0;
            last_q  <= 1'b0;
         end else if (eom_i) begin
            empty_q <= 1'b0;
            last_q  <= 1'b1;
         end else if (rd_done_i) begin
            empty_q <= 1'b1;
         end
         if (set_err_i)      err_q <= 1'b1;
         else if (rd_done_i) err_q <= 1'b0;
         if (set_mis_i)      mis_q <= 1'b1;
         else if (clr_mis_i) mis_q <= 1'b0;
      end
   end

   always_comb begin
      word_o                      = '0;
      word_o[BIT_EMPTY]           = empty_q;
      word_o[BIT_LAST]            = last_q;
      word_o[BIT_ERR]             = err_q;
      word_o[BIT_MIS]             = mis_q;
      word_o[WORD_W-1:FLAG_W]     = data_q;
   end
   assign empty_o = empty_q;

   // R2: a write occupies the descriptor and clears Last
   p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && !init_i |=> !empty_q && !last_q);
   // R3: an agreeing pair leaves Mismatch clear
   p_pair_clears_mis_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mis_i && !init_i |=> !mis_q);
   // R8: end-of-message never touches the data field
   p_eom_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eom_i && !init_i |=> $stable(data_q) && last_q);
endmodule

// File: rtl/mon_rx_aline.sv
module mon_rx_aline
   import mon_rx_pkg::*;
#(
   parameter int ABORT_FRAMES = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   init_i,
   input  logic   strobe_i,
   input  logic   ack_i,
   input  logic   abort_i,
   output aline_e code_o
);
   aline_e code_q;
   logic   req_q;
   logic   hold_abort;

   generate
      if (ABORT_FRAMES == 1) begin : g_one
         assign hold_abort = 1'b0;
      end else begin : g_multi
         localparam int LW = $clog2(ABORT_FRAMES);
         logic [LW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (init_i) begin
               left_q <= '0;
            end else if (strobe_i) begin
               if (req_q)               left_q <= LW'(ABORT_FRAMES - 1);
               else if (left_q != '0)   left_q <= left_q - 1'b1;
            end
         end
         assign hold_abort = (left_q != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= A_IDLE;
         req_q  <= 1'b0;
      end else if (init_i) begin
         code_q <= A_IDLE;
         req_q  <= 1'b0;
      end else begin
         if (abort_i)       req_q <= 1'b1;
         else if (strobe_i) req_q <= 1'b0;
         if (strobe_i) begin
            if (req_q || hold_abort) code_q <= A_ABORT;
            else if (ack_i)          code_q <= A_ACK;
            else                     code_q <= A_IDLE;
         end
      end
   end
   assign code_o = code_q;

   // R6: only the three defined codes appear
   p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      code_q != 2'b11);
   // R7: a pending abort request takes effect at the next strobe
   p_abort_applies_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i && req_q && !init_i |=> code_q == A_ABORT);
endmodule

// File: rtl/mon_rx_top.sv
module mon_rx_top
   import mon_rx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int IDLE_FRAMES  = 2,
   parameter int ABORT_FRAMES = 1,
   localparam int WORD_W = DATA_W + FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_strobe_i,
   input  logic              e_active_i,
   input  logic [DATA_W-1:0] mon_byte_i,
   input  logic              rd_done_i,
   input  logic              abort_cmd_i,
   input  logic              init_cmd_i,
   output logic [WORD_W-1:0] desc_word_o,
   output logic [1:0]        a_code_o
);
   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (IDLE_FRAMES >= 1) else $error("IDLE_FRAMES must be at least 1");
      assert (ABORT_FRAMES >= 1) else $error("ABORT_FRAMES must be at least 1");
   end

   logic              wr, set_err, set_mis, clr_mis, pend, eom, empty;
   logic [DATA_W-1:0] wr_data;
   aline_e            code;

   mon_rx_filter #(.DATA_W(DATA_W)) u_filter (
      .clk(clk), .rst_n(rst_n), .init_i(init_cmd_i),
      .strobe_i(frame_strobe_i), .e_act_i(e_active_i), .byte_i(mon_byte_i),
      .empty_i(empty), .wr_o(wr), .wr_data_o(wr_data),
      .set_err_o(set_err), .set_mis_o(set_mis), .clr_mis_o(clr_mis), .pend_o(pend)
   );

   mon_rx_eom #(.IDLE_FRAMES(IDLE_FRAMES)) u_eom (
      .clk(clk), .rst_n(rst_n), .init_i(init_cmd_i),
      .strobe_i(frame_strobe_i), .e_act_i(e_active_i), .pend_i(pend),
      .empty_i(empty), .wr_i(wr), .eom_o(eom)
   );

   mon_rx_desc #(.DATA_W(DATA_W)) u_desc (
      .clk(clk), .rst_n(rst_n), .init_i(init_cmd_i),
      .wr_i(wr), .wr_data_i(wr_data), .set_err_i(set_err),
      .set_mis_i(set_mis), .clr_mis_i(clr_mis), .eom_i(eom),
      .rd_done_i(rd_done_i), .empty_o(empty), .word_o(desc_word_o)
   );

   mon_rx_aline #(.ABORT_FRAMES(ABORT_FRAMES)) u_aline (
      .clk(clk), .rst_n(rst_n), .init_i(init_cmd_i),
      .strobe_i(frame_strobe_i), .ack_i(wr), .abort_i(abort_cmd_i), .code_o(code)
   );

   assign a_code_o = code;

   // R4: no acknowledge while the descriptor is occupied
   p_no_ack_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_strobe_i && !desc_word_o[BIT_EMPTY] && !init_cmd_i |=> a_code_o != A_ACK);
   // R9: init restores the reset view at the ports
   p_init_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
      init_cmd_i |=> desc_word_o == WORD_W'(1) && a_code_o == A_IDLE);
endmodule

// File: tb/mon_rx_top_tb.sv
module mon_rx_top_tb;
   localparam int DW = 8;
   localparam int WW = 16;
   localparam int ABF = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strobe = 1'b0, e_act = 1'b0;
   logic [DW-1:0] mbyte = '0;
   logic          rd_man = 1'b0, rd_mon = 1'b0;
   logic          abort = 1'b0, init = 1'b0;
   logic          auto_rd = 1'b0;
   wire           rd_done = rd_man | rd_mon;
   logic [WW-1:0] word;
   logic [1:0]    acode;

   int checks = 0;
   int fails  = 0;
   logic [WW-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   mon_rx_top #(.DATA_W(DW), .IDLE_FRAMES(2), .ABORT_FRAMES(ABF)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_strobe_i(strobe), .e_active_i(e_act),
      .mon_byte_i(mbyte), .rd_done_i(rd_done), .abort_cmd_i(abort),
      .init_cmd_i(init), .desc_word_o(word), .a_code_o(acode)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic frame(input bit e, input logic [DW-1:0] b);
      @(negedge clk);
      strobe = 1'b1; e_act = e; mbyte = b;
      @(negedge clk);
      strobe = 1'b0; e_act = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic read_done();
      @(negedge clk); rd_man = 1'b1;
      @(negedge clk); rd_man = 1'b0;
   endtask

   // scoreboard monitor: consumes the descriptor when auto-read is on
   always @(negedge clk) begin
      if (rd_mon) begin
         rd_mon = 1'b0;
      end else if (auto_rd && rst_n && !word[0]) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected write", word, 0);
         end else begin
            logic [WW-1:0] e;
            e = exp_q.pop_front();
            chk(word == e, "R2 scoreboard word", word, e);
         end
         rd_mon = 1'b1;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      $display("FAIL watchdog actual=running expected=done");
      checks++; fails++;
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(word == 16'h0001, "R1 reset word", word, 16'h0001);
      chk(acode == 2'b00, "R6 reset code", acode, 0);

      // R2 via scoreboard
      auto_rd = 1'b1;
      exp_q.push_back(16'hA500);
      frame(1, 8'hA5); frame(1, 8'hA5);
      chk(acode == 2'b01, "R6 ack after write", acode, 1);
      exp_q.push_back(16'h3C00);
      frame(1, 8'h3C); frame(1, 8'h3C);
      repeat (4) @(negedge clk);
      auto_rd = 1'b0;

      // R3 mismatch
      frame(1, 8'h11); frame(1, 8'h22);
      chk(word == 16'h3C09, "R3 mismatch set, no write", word, 16'h3C09);
      frame(1, 8'h22);
      chk(word == 16'h2200, "R3 agreeing pair clears mismatch", word, 16'h2200);

      // R4 held pending while full
      frame(1, 8'h44); frame(1, 8'h44);
      chk(acode == 2'b00, "R4 no ack while full", acode, 0);
      chk(word == 16'h2200, "R4 word unchanged while full", word, 16'h2200);
      read_done();
      chk(word == 16'h2201, "R4 read-done sets empty", word, 16'h2201);
      frame(1, 8'h44);
      chk(word == 16'h4400, "R4 pending byte written", word, 16'h4400);
      chk(acode == 2'b01, "R4 ack on pending write", acode, 1);

      // R10 fresh pair
      read_done();
      frame(1, 8'h44);
      chk(word == 16'h4401, "R10 single copy no rewrite", word, 16'h4401);
      frame(1, 8'h44);
      chk(word == 16'h4400, "R10 fresh pair writes", word, 16'h4400);
      read_done();

      // R5 error
      frame(1, 8'h55); frame(1, 8'h55);
      frame(1, 8'h66); frame(1, 8'h66);
      frame(1, 8'h77);
      chk(word == 16'h5504, "R5 error set", word, 16'h5504);
      chk(acode == 2'b00, "R5 no ack on error", acode, 0);
      read_done();
      chk(word == 16'h5501, "R5 read-done clears error", word, 16'h5501);

      // R8 end of message
      frame(0, 8'h00);
      chk(word == 16'h5501, "R8 one idle frame not enough", word, 16'h5501);
      frame(0, 8'h00);
      chk(word == 16'h5502, "R8 last set", word, 16'h5502);
      read_done();
      frame(0, 8'h00);
      chk(word == 16'h5503, "R8 only once per message", word, 16'h5503);

      // R7 abort
      @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
      frame(0, 8'h00);
      chk(acode == 2'b10, "R7 abort frame 1", acode, 2);
      frame(0, 8'h00);
      chk(acode == 2'b10, "R7 abort frame 2", acode, 2);
      frame(0, 8'h00);
      chk(acode == 2'b00, "R7 abort ends", acode, 0);
      frame(1, 8'h12);
      @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
      frame(1, 8'h12);
      chk(acode == 2'b10, "R7 abort overrides ack", acode, 2);
      chk(word == 16'h1200, "R7 byte still written", word, 16'h1200);

      // R9 init wins over abort
      frame(1, 8'h9A);
      @(negedge clk); abort = 1'b1; init = 1'b1;
      @(negedge clk); abort = 1'b0; init = 1'b0;
      chk(word == 16'h0001, "R9 init word", word, 16'h0001);
      chk(acode == 2'b00, "R9 init code", acode, 0);
      frame(1, 8'h9A);
      chk(word == 16'h0001, "R9 partial byte discarded", word, 16'h0001);
      chk(acode == 2'b00, "R9 abort dropped", acode, 0);

      chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      summary();
   end
endmodule